// File: doc/BRIEF.md
# Overlapped ADC Conversion Sequencer

This block generates the digital timing for a successive-approximation converter. Each trigger opens an acquisition window whose length comes from a 6-bit setting. A fixed 13-cycle conversion phase follows. The result is presented by the converter on the next cycle and captured into a result register one cycle later. The capture pulses an end-of-conversion strobe and tags the data with the channel that came with the trigger.

In overlap mode, a pending acquisition may start while the previous conversion is still running. Because of this, an acquisition can end exactly on the presentation cycle of the earlier result, which makes that result unreliable. The block flags that alignment. A guard option removes it by stretching the acquisition by one cycle. A non-overlap mode serialises acquisitions behind completed results, so the alignment can never happen.

Top module: `adc_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `sample_o`, `convert_o`, `present_o`, `eoc_o`, `hazard_o`, `overflow_o` and `res_valid_o` are all low.
- R2: `sample_o` stays high for S+1 consecutive cycles, where S is `acq_set_i` captured when the acquisition starts. Settings below 6 are treated as 6.
- R3: Take the last high cycle of `sample_o` as cycle 0. Then `convert_o` is high in cycles 1 to 13, `present_o` is high in cycle 14, and `eoc_o` is high for exactly cycle 15.
- R4: From cycle 15 on, `res_data_o` holds the `conv_data_i` value that was present during cycle 14. `res_chan_o` holds the `chan_i` value given with the trigger, and `res_valid_o` is high.
- R5: In overlap mode (`nonovl_i` low), a pending acquisition begins no earlier than conversion cycle 7 of the running conversion. Back-to-back conversions at setting 6 therefore end each acquisition on cycle 13 and raise no hazard.
- R6: With the guard off, an acquisition whose last cycle is the presentation cycle of another conversion raises `hazard_o` for one cycle, in the following cycle. That following cycle is also that conversion's `eoc_o` cycle.
- R7: With `guard_i` high, such an acquisition is stretched by one cycle and `hazard_o` stays low.
- R8: With `nonovl_i` high, a pending acquisition starts no earlier than the cycle after the previous conversion's `eoc_o`, and `hazard_o` stays low for any setting.
- R9: A trigger arriving while a trigger is already pending raises `overflow_o` in the next cycle. That trigger is dropped and produces no conversion.
- R10: When the block is idle, a trigger sampled at the end of cycle c makes `sample_o` high first in cycle c+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start request, sampled every cycle |
| chan_i | input | CH_W | Channel tag captured with an accepted trigger |
| acq_set_i | input | SET_W | Acquisition setting, window is setting+1 cycles |
| nonovl_i | input | 1 | Non-overlap mode |
| guard_i | input | 1 | Stretch an acquisition that would end on a presentation cycle |
| conv_data_i | input | DATA_W | Converter output, valid in the presentation cycle |
| sample_o | output | 1 | Acquisition strobe to the converter |
| convert_o | output | 1 | Conversion phase strobe |
| present_o | output | 1 | Presentation cycle strobe |
| res_data_o | output | DATA_W | Result register |
| res_chan_o | output | CH_W | Channel tag of the result |
| res_valid_o | output | 1 | Result register holds a result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| hazard_o | output | 1 | Unsafe alignment occurred |
| overflow_o | output | 1 | Trigger dropped |

## Verification
All timing is measured from the last high cycle of `sample_o`. The end-of-conversion pulse and the new result are due 15 cycles after that cycle. The first sample cycle is due 2 cycles after an idle trigger. Hazard and overflow pulses are due one cycle after their cause. A monitor logs every sample edge by cycle number and pops one expected item per `eoc_o`, checking data, tag, window length and the 15-cycle distance. The overlap scenarios fire the second trigger on a cycle computed from the logged end of the first acquisition. This places its acquisition end exactly on conversion cycle 13, 14 or 15, and the hazard count and start distance are checked against that placement.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CH_W     = 4,
  parameter int DATA_W   = 12,
  parameter int SET_W    = 6,
  parameter int MIN_SET  = 6,
  parameter int CONV_CYC = 13,
  parameter int OVL_FROM = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [SET_W-1:0]  acq_set_i,
  input  logic              nonovl_i,
  input  logic              guard_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sample_o,
  output logic              convert_o,
  output logic              present_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic              res_valid_o,
  output logic              eoc_o,
  output logic              hazard_o,
  output logic              overflow_o
);
  localparam int CNT_W = $clog2(CONV_CYC + 1);
  localparam logic [SET_W-1:0] MIN_S  = SET_W'(MIN_SET);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CONV_CYC);
  localparam logic [CNT_W-1:0] OVL_C  = CNT_W'(OVL_FROM);

  logic              pend_q, samp_q, ext_q, pres_q, eoc_q, haz_q, ovf_q, valid_q;
  logic [CH_W-1:0]   pend_ch_q, acq_ch_q, conv_ch_q, pres_ch_q, res_ch_q;
  logic [SET_W-1:0]  acq_cnt_q, acq_set_q;
  logic [CNT_W-1:0]  conv_cnt_q;
  logic [DATA_W-1:0] res_q;

  logic [SET_W-1:0] set_eff;
  logic conv_busy, may_start, start, last_nom, collide, stretch, acq_end;

  assign set_eff   = (acq_set_i < MIN_S) ? MIN_S : acq_set_i;
  assign conv_busy = conv_cnt_q != '0;
  assign may_start = nonovl_i ? (!conv_busy && !pres_q)
                              : (!conv_busy || conv_cnt_q >= OVL_C);
  assign start     = pend_q && !samp_q && may_start;
  assign last_nom  = samp_q && !ext_q && (acq_cnt_q == acq_set_q);
  assign collide   = last_nom && pres_q;
  assign stretch   = collide && guard_i;
  assign acq_end   = (last_nom && !stretch) || (samp_q && ext_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_ch_q  <= '0;
      ovf_q      <= 1'b0;
    end else begin
      ovf_q <= trig_i && pend_q;
      if (start) pend_q <= 1'b0;
      if (trig_i && !pend_q) begin
        pend_q    <= 1'b1;
        pend_ch_q <= chan_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q    <= 1'b0;
      ext_q     <= 1'b0;
      acq_cnt_q <= '0;
      acq_set_q <= '0;
      acq_ch_q  <= '0;
      haz_q     <= 1'b0;
    end else begin
      haz_q <= collide && !guard_i;
      if (start) begin
        samp_q    <= 1'b1;
        ext_q     <= 1'b0;
        acq_cnt_q <= '0;
        acq_set_q <= set_eff;
        acq_ch_q  <= pend_ch_q;
      end else if (samp_q) begin
        if (acq_end)      samp_q    <= 1'b0;
        else if (stretch) ext_q     <= 1'b1;
        else              acq_cnt_q <= acq_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_cnt_q <= '0;
      conv_ch_q  <= '0;
      pres_q     <= 1'b0;
      pres_ch_q  <= '0;
      eoc_q      <= 1'b0;
      valid_q    <= 1'b0;
      res_q      <= '0;
      res_ch_q   <= '0;
    end else begin
      if (acq_end) begin
        conv_cnt_q <= CNT_W'(1);
        conv_ch_q  <= acq_ch_q;
      end else if (conv_cnt_q == LAST_C) begin
        conv_cnt_q <= '0;
      end else if (conv_busy) begin
        conv_cnt_q <= conv_cnt_q + 1'b1;
      end
      pres_q <= conv_cnt_q == LAST_C;
      if (conv_cnt_q == LAST_C) pres_ch_q <= conv_ch_q;
      eoc_q <= pres_q;
      if (pres_q) begin
        res_q    <= conv_data_i;
        res_ch_q <= pres_ch_q;
        valid_q  <= 1'b1;
      end
    end
  end

  assign sample_o    = samp_q;
  assign convert_o   = conv_busy;
  assign present_o   = pres_q;
  assign eoc_o       = eoc_q;
  assign res_data_o  = res_q;
  assign res_chan_o  = res_ch_q;
  assign res_valid_o = valid_q;
  assign hazard_o    = haz_q;
  assign overflow_o  = ovf_q;

  // R3
  conv_to_present_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(convert_o) |-> present_o);
  // R3
  present_to_eoc_chk: assert property (@(posedge clk) disable iff (rst)
    present_o |=> (eoc_o && res_valid_o));
  // R6
  hazard_on_eoc_chk: assert property (@(posedge clk) disable iff (rst)
    hazard_o |-> eoc_o);
  // R7
  guard_no_hazard_chk: assert property (@(posedge clk) disable iff (rst)
    $past(guard_i) |-> !hazard_o);
  // R8
  nonovl_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(nonovl_i) && $rose(sample_o)) |-> (!convert_o && !present_o));
  // R9
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(trig_i));
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic [3:0]  chan = '0;
  logic [5:0]  acq_set = 6'd10;
  logic nonovl = 1'b0;
  logic guard = 1'b0;
  logic [11:0] conv_data;
  logic [11:0] stub_k;
  logic sample_o, convert_o, present_o, res_valid_o, eoc_o, hazard_o, overflow_o;
  logic [11:0] res_data_o;
  logic [3:0]  res_chan_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq u_adc_seq (
    .clk(clk), .rst(rst), .trig_i(trig), .chan_i(chan), .acq_set_i(acq_set),
    .nonovl_i(nonovl), .guard_i(guard), .conv_data_i(conv_data),
    .sample_o(sample_o), .convert_o(convert_o), .present_o(present_o),
    .res_data_o(res_data_o), .res_chan_o(res_chan_o), .res_valid_o(res_valid_o),
    .eoc_o(eoc_o), .hazard_o(hazard_o), .overflow_o(overflow_o));

  always @(posedge clk) begin
    if (rst) stub_k <= '0;
    else if (present_o) stub_k <= stub_k + 12'd1;
  end
  assign conv_data = 12'h500 + stub_k;

  typedef struct { int ch; int data; int slen; } exp_t;
  exp_t exp_q[$];
  int len_q[$], end_q[$], rise_cyc[$], last_cyc[$];
  int cyc = 0, n_chk = 0, n_bad = 0, n_acc = 0, hz_cnt = 0, ov_cnt = 0, run = 0;
  bit prev_s = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      prev_s = 1'b0;
      run = 0;
    end else begin
      if (sample_o) run++;
      if (sample_o && !prev_s) rise_cyc.push_back(cyc);
      if (!sample_o && prev_s) begin
        last_cyc.push_back(cyc - 1);
        end_q.push_back(cyc - 1);
        len_q.push_back(run);
        run = 0;
      end
      if (hazard_o) hz_cnt++;
      if (overflow_o) ov_cnt++;
      if (eoc_o) begin
        if (exp_q.size() == 0 || len_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected eoc count", 1, 0);
        end else begin
          exp_t e;
          int l, ecy;
          e = exp_q.pop_front();
          l = len_q.pop_front();
          ecy = end_q.pop_front();
          chk(res_data_o == 12'(e.data), "R4", "result data", int'(res_data_o), e.data);
          chk(res_chan_o == 4'(e.ch), "R4", "channel tag", int'(res_chan_o), e.ch);
          chk(res_valid_o, "R4", "valid flag", int'(res_valid_o), 1);
          chk(l == e.slen, "R2", "sample window length", l, e.slen);
          chk(cyc - ecy == 15, "R3", "eoc distance", cyc - ecy, 15);
        end
      end
      prev_s = sample_o;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic fire(input int ch, input int slen);
    exp_t e;
    trig = 1'b1;
    chan = 4'(ch);
    e.ch = ch; e.data = 'h500 + n_acc; e.slen = slen;
    exp_q.push_back(e);
    n_acc++;
    step();
    trig = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) step();
    repeat (4) step();
  endtask

  task automatic pair(input int set, input bit late, input int la, input int lb,
                      input int want_gap, input int want_hz, input string req);
    int h0, n;
    acq_set = 6'(set);
    h0 = hz_cnt;
    n = last_cyc.size();
    fire(1, la);
    if (!late) begin
      repeat (3) step();
      fire(2, lb);
    end else begin
      while (last_cyc.size() == n) step();
      repeat (5) step();
      fire(2, lb);
    end
    settle();
    chk(rise_cyc[$] - last_cyc[$-1] == want_gap, req, "second start distance",
        rise_cyc[$] - last_cyc[$-1], want_gap);
    chk(hz_cnt - h0 == want_hz, req, "hazard pulses", hz_cnt - h0, want_hz);
  endtask

  initial begin
    repeat (3) step();
    chk(!sample_o && !convert_o && !present_o && !eoc_o && !hazard_o && !overflow_o && !res_valid_o,
        "R1", "outputs in reset", 1, 0);
    rst = 1'b0;
    step();
    chk(!sample_o && !convert_o && !present_o && !eoc_o && !hazard_o && !overflow_o && !res_valid_o,
        "R1", "outputs after reset", 1, 0);

    // R10 idle latency, R2 length 11, R3/R4 via monitor
    acq_set = 6'd10;
    fire(3, 11);
    chk(!sample_o, "R10", "sample one cycle after trigger", int'(sample_o), 0);
    step();
    chk(sample_o, "R10", "sample two cycles after trigger", int'(sample_o), 1);
    settle();

    // R2 setting below minimum acts as 6
    acq_set = 6'd2;
    fire(5, 7);
    settle();

    // R5 continuous at 6: start on conv cycle 7, no hazard
    pair(6, 1'b0, 7, 7, 7, 0, "R5");
    // R6 setting 7 overlapped: ends on presentation cycle
    pair(7, 1'b0, 8, 8, 7, 1, "R6");
    // R6 setting 6 late start: ends on presentation cycle
    pair(6, 1'b1, 7, 7, 8, 1, "R6");
    // R7 guard stretches by one cycle
    guard = 1'b1;
    pair(6, 1'b1, 7, 8, 8, 0, "R7");
    guard = 1'b0;
    // R5 setting 8 is safe
    pair(8, 1'b0, 9, 9, 7, 0, "R5");
    // R8 non-overlap serialises behind eoc
    nonovl = 1'b1;
    pair(7, 1'b0, 8, 8, 16, 0, "R8");
    nonovl = 1'b0;

    // R9 overflow: trigger held two cycles
    begin
      int o0, r0;
      exp_t e;
      acq_set = 6'd6;
      o0 = ov_cnt;
      r0 = rise_cyc.size();
      trig = 1'b1; chan = 4'd9;
      e.ch = 9; e.data = 'h500 + n_acc; e.slen = 7;
      exp_q.push_back(e);
      n_acc++;
      step();
      chk(!overflow_o, "R9", "no overflow on first trigger", int'(overflow_o), 0);
      chan = 4'd4;
      step();
      trig = 1'b0;
      chk(overflow_o, "R9", "overflow pulse", int'(overflow_o), 1);
      settle();
      chk(ov_cnt - o0 == 1, "R9", "overflow pulses", ov_cnt - o0, 1);
      chk(rise_cyc.size() - r0 == 1, "R9", "acquisitions started", rise_cyc.size() - r0, 1);
    end

    chk(exp_q.size() == 0, "R3", "results outstanding", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule